// File: doc/BRIEF.md
# Per-Channel Gain and Offset Correction Engine

This block holds calibration state for a bank of converter channels and turns each channel's raw code into a corrected code. Every channel keeps three values: a raw 14-bit input word, a 13-bit gain coefficient and a 14-bit offset coefficient. The corrected code is the input scaled by (gain + 1) / 8192, plus the offset read as an excess-8192 number. The sum is saturated to the 14-bit code range rather than allowed to wrap. With the gain at all ones and the offset at 0x2000, the corrected code equals the input word.

A single synchronous write port takes a channel number, a register select and a data word. Any accepted write marks its channel as needing recomputation. A shared arithmetic unit then works through the marked channels, one channel per clock. It stores each result in that channel's result register, and the register can be read at any time through a combinational read port. A busy output shows that at least one channel still waits for its result. Writes are accepted while busy. A write to the channel being computed in that same cycle marks the channel again, so its final result reflects the newest values.

Top module: `gocorr_top`

## Requirements
- R1: After reset every channel's result reads 0x2000 and busy is low. The stored values are input 0x2000, gain 0x1FFF and offset 0x2000.
- R2: Before saturation the result equals floor((gain + 1) × input / 8192) + offset − 8192. A gain of 0x1FFF with an offset of 0x2000 returns the input word unchanged.
- R3: The offset is excess-8192: the code 0x209C adds 156 to the scaled input and the code 0x1F64 subtracts 156.
- R4: A pre-saturation value above 16383 yields a result of 0x3FFF.
- R5: A pre-saturation value below zero yields a result of 0.
- R6: A write with select 0 (input word), 1 (gain) or 2 (offset) to a channel below 40 stores the data and marks the channel pending. Busy is high in the cycle after the write edge. When nothing else is pending, the new result is readable after the second clock edge counted from the write edge.
- R7: At most one channel's result is updated per clock, and only for a channel that is pending.
- R8: Busy is high exactly while some channel is pending. While busy is low and no write is made, no result changes.
- R9: A write that lands on a channel in the same clock as that channel's recomputation is accepted. The channel is recomputed again in a later clock, so its settled result uses the latest stored values.
- R10: A write with select 3, or with a channel number of 40 or more, changes no stored value and marks nothing pending. Reading a channel number of 40 or more returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_ch | input | 6 | Channel number of the write |
| wr_sel | input | 2 | Register select: 0 input word, 1 gain, 2 offset, 3 none |
| wr_data | input | 14 | Write data (gain uses the low 13 bits) |
| rd_ch | input | 6 | Channel number to read |
| rd_code | output | 14 | Corrected code of channel rd_ch |
| busy | output | 1 | At least one channel awaits recomputation |

## Verification
Two functions can fall in the same cycle: a channel's result is recomputed from its stored values, and a new write lands on that same channel. The bench provokes this by writing a channel's input word and then writing its gain on the very next clock, when the shared unit is computing that channel. It checks that the intermediate result uses the old gain, that busy stays high and that the next clock gives the result with the new gain. A long stream of back-to-back writes to random channels, compared every clock against a behavioural model, covers the same collision at many points in the bank.

// File: rtl/gocorr_pkg.sv
package gocorr_pkg;

    localparam int CODE_W = 14;
    localparam int GAIN_W = 13;

    typedef enum logic [1:0] {
        SEL_INPUT  = 2'd0,
        SEL_GAIN   = 2'd1,
        SEL_OFFSET = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [CODE_W-1:0] x1;
        logic [GAIN_W-1:0] m;
        logic [CODE_W-1:0] c;
    } chan_coef_t;

    localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1) << (CODE_W - 1);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;
    localparam logic [GAIN_W-1:0] GAIN_UNITY = '1;

    localparam chan_coef_t COEF_RST = '{x1: CODE_MID, m: GAIN_UNITY, c: CODE_MID};

endpackage

// File: rtl/gocorr_calc.sv
module gocorr_calc
    import gocorr_pkg::*;
(
    input  chan_coef_t        coef,
    output logic [CODE_W-1:0] code
);
    localparam int PROD_W = CODE_W + GAIN_W + 1;
    localparam int SCL_W  = PROD_W - GAIN_W;
    localparam int SUM_W  = CODE_W + 3;

    logic [GAIN_W:0]          gain_p1;
    logic [PROD_W-1:0]        prod;
    logic [SCL_W-1:0]         scaled;
    logic signed [SUM_W-1:0]  sum;

    always_comb begin
        gain_p1 = {1'b0, coef.m} + (GAIN_W+1)'(1);
        prod    = PROD_W'(gain_p1) * PROD_W'(coef.x1);
        scaled  = prod[PROD_W-1:GAIN_W];
        sum     = $signed(SUM_W'(scaled)) + $signed(SUM_W'(coef.c))
                - $signed(SUM_W'(CODE_MID));
        if (sum < 0)
            code = '0;
        else if (sum > $signed(SUM_W'(CODE_MAX)))
            code = CODE_MAX;
        else
            code = sum[CODE_W-1:0];
    end
endmodule

// File: rtl/gocorr_sched.sv
module gocorr_sched #(
    parameter int NUM_CH = 40,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] pending,
    output logic              gnt_valid,
    output logic [CH_W-1:0]   gnt_idx,
    output logic [NUM_CH-1:0] gnt_vec
);
    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (pending[i]) begin
                gnt_valid = 1'b1;
                gnt_idx   = CH_W'(i);
            end
        end
        gnt_vec = gnt_valid ? (NUM_CH'(1) << gnt_idx) : '0;
    end
endmodule

// File: rtl/gocorr_bank.sv
module gocorr_bank
    import gocorr_pkg::*;
#(
    parameter int NUM_CH = 40,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [1:0]        wr_sel,
    input  logic [CODE_W-1:0] wr_data,
    input  logic [NUM_CH-1:0] gnt_vec,
    input  logic [CH_W-1:0]   gnt_idx,
    output logic [NUM_CH-1:0] pending,
    output chan_coef_t        gnt_coef
);
    reg_sel_e   sel;
    chan_coef_t coef_arr [NUM_CH];

    assign sel = reg_sel_e'(wr_sel);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic       hit;
        logic       pend_q;
        chan_coef_t coef_q;

        assign hit = wr_en && (wr_ch == CH_W'(g)) && (sel != SEL_NONE);

        always_ff @(posedge clk) begin
            if (rst) begin
                coef_q <= COEF_RST;
                pend_q <= 1'b0;
            end else begin
                if (hit) begin
                    case (sel)
                        SEL_INPUT:  coef_q.x1 <= wr_data;
                        SEL_GAIN:   coef_q.m  <= wr_data[GAIN_W-1:0];
                        SEL_OFFSET: coef_q.c  <= wr_data;
                        default:    coef_q    <= coef_q;
                    endcase
                    pend_q <= 1'b1;
                end else if (gnt_vec[g]) begin
                    pend_q <= 1'b0;
                end
            end
        end

        assign pending[g]  = pend_q;
        assign coef_arr[g] = coef_q;
    end

    assign gnt_coef = (gnt_idx < CH_W'(NUM_CH)) ? coef_arr[gnt_idx] : COEF_RST;
endmodule

// File: rtl/gocorr_top.sv
module gocorr_top
    import gocorr_pkg::*;
#(
    parameter int NUM_CH = 40,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [1:0]        wr_sel,
    input  logic [CODE_W-1:0] wr_data,
    input  logic [CH_W-1:0]   rd_ch,
    output logic [CODE_W-1:0] rd_code,
    output logic              busy
);
    logic [NUM_CH-1:0] pending;
    logic [NUM_CH-1:0] gnt_vec;
    logic              gnt_valid;
    logic [CH_W-1:0]   gnt_idx;
    chan_coef_t        gnt_coef;
    logic [CODE_W-1:0] calc_code;
    logic [CODE_W-1:0] res_arr [NUM_CH];

    gocorr_bank #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_ch    (wr_ch),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .gnt_vec  (gnt_vec),
        .gnt_idx  (gnt_idx),
        .pending  (pending),
        .gnt_coef (gnt_coef)
    );

    gocorr_sched #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_sched (
        .pending   (pending),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx),
        .gnt_vec   (gnt_vec)
    );

    gocorr_calc u_calc (
        .coef (gnt_coef),
        .code (calc_code)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_res
        logic [CODE_W-1:0] res_q;
        always_ff @(posedge clk) begin
            if (rst)
                res_q <= CODE_MID;
            else if (gnt_valid && gnt_vec[g])
                res_q <= calc_code;
        end
        assign res_arr[g] = res_q;
    end

    assign rd_code = (rd_ch < CH_W'(NUM_CH)) ? res_arr[rd_ch] : '0;
    assign busy    = |pending;
endmodule

// File: rtl/gocorr_chk.sv
module gocorr_chk
    import gocorr_pkg::*;
#(
    parameter int NUM_CH = 40,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [CH_W-1:0]   wr_ch,
    input logic [1:0]        wr_sel,
    input logic [CH_W-1:0]   rd_ch,
    input logic [CODE_W-1:0] rd_code,
    input logic              busy,
    input logic [NUM_CH-1:0] pending,
    input logic [NUM_CH-1:0] gnt_vec
);
    logic valid_wr;
    assign valid_wr = wr_en && (wr_ch < CH_W'(NUM_CH)) && (wr_sel != 2'd3);

    AST_GRANT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_vec));                                              // R7
    AST_GRANT_OWNS_PENDING: assert property (@(posedge clk) disable iff (rst)
        (gnt_vec & ~pending) == '0);                                     // R7
    AST_WRITE_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
        valid_wr |=> busy);                                              // R6
    AST_IDLE_FREEZES_CODE: assert property (@(posedge clk) disable iff (rst)
        (!busy && !wr_en) |=> (rd_code == $past(rd_code) || rd_ch != $past(rd_ch))); // R8
    AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (rst)
        (busy && !wr_en && $countones(pending) == 1) |=> !busy);         // R8
    AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!busy && wr_en && !valid_wr) |=> !busy);                        // R10
endmodule

bind gocorr_top gocorr_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_ch   (wr_ch),
    .wr_sel  (wr_sel),
    .rd_ch   (rd_ch),
    .rd_code (rd_code),
    .busy    (busy),
    .pending (pending),
    .gnt_vec (gnt_vec)
);

// File: tb/gocorr_top_test.sv
module gocorr_top_test;
    localparam int NUM_CH = 40;
    localparam int CH_W   = 6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [CH_W-1:0]   wr_ch = '0;
    logic [1:0]        wr_sel = '0;
    logic [13:0]       wr_data = '0;
    logic [CH_W-1:0]   rd_ch = '0;
    logic [13:0]       rd_code;
    logic              busy;

    int n_checks = 0;
    int n_errors = 0;
    string cur_req = "R1";

    int mx1 [NUM_CH];
    int mm  [NUM_CH];
    int mc  [NUM_CH];
    int mres[NUM_CH];
    bit mpend[NUM_CH];

    always #4 clk = ~clk;

    gocorr_top #(.NUM_CH(NUM_CH), .CH_W(CH_W)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_ch(rd_ch), .rd_code(rd_code), .busy(busy)
    );

    function automatic int ref_code(int x1, int m, int c);
        int v;
        v = ((m + 1) * x1) / 8192 + c - 8192;
        if (v < 0) v = 0;
        if (v > 16383) v = 16383;
        return v;
    endfunction

    function automatic bit any_pend();
        bit a = 0;
        for (int i = 0; i < NUM_CH; i++) a |= mpend[i];
        return a;
    endfunction

    task automatic check(string req, int got, int exp, string what);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // behavioural reference: one pending channel served per clock, lowest first
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_CH; i++) begin
                mx1[i] = 8192; mm[i] = 8191; mc[i] = 8192; mres[i] = 8192; mpend[i] = 0;
            end
        end else begin
            int p;
            p = -1;
            for (int i = NUM_CH - 1; i >= 0; i--) if (mpend[i]) p = i;
            if (p >= 0) begin
                mres[p] = ref_code(mx1[p], mm[p], mc[p]);
                mpend[p] = 0;
            end
            if (wr_en && int'(wr_ch) < NUM_CH && wr_sel != 2'd3) begin
                case (wr_sel)
                    2'd0: mx1[wr_ch] = int'(wr_data);
                    2'd1: mm[wr_ch]  = int'(wr_data[12:0]);
                    default: mc[wr_ch] = int'(wr_data);
                endcase
                mpend[wr_ch] = 1;
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            int exp;
            exp = (int'(rd_ch) < NUM_CH) ? mres[rd_ch] : 0;
            check(cur_req, int'(rd_code), exp, "model code");
            check(cur_req, int'(busy), int'(any_pend()), "model busy");
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic drive_wr(int ch, int sel, int data);
        wr_en = 1'b1; wr_ch = CH_W'(ch); wr_sel = 2'(sel); wr_data = 14'(data);
        step();
        wr_en = 1'b0;
    endtask

    task automatic read_chk(string req, int ch, int exp);
        rd_ch = CH_W'(ch);
        @(negedge clk); #1;
        check(req, int'(rd_code), exp, "directed code");
        step();
    endtask

    initial begin
        #(8 * 150000);
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        step();

        // R1: reset values
        cur_req = "R1";
        check("R1", int'(busy), 0, "busy after reset");
        for (int ch = 0; ch < NUM_CH; ch++) read_chk("R1", ch, 16'h2000);

        // R2: unity gain and midscale offset pass the input through
        cur_req = "R2";
        drive_wr(0, 0, 16'h1234);
        step(); step();
        read_chk("R2", 0, 16'h1234);

        // R6: busy one cycle after the write edge, result after the second edge
        cur_req = "R6";
        rd_ch = 6'd1;
        drive_wr(1, 0, 16'h0100);
        check("R6", int'(busy), 1, "busy after write");
        check("R6", int'(rd_code), 16'h2000, "result before compute");
        step();
        check("R6", int'(rd_code), 16'h0100, "result after compute");
        check("R6", int'(busy), 0, "busy after compute");

        // R2 gain and R3 offset
        cur_req = "R3";
        drive_wr(2, 1, 8035);
        drive_wr(2, 0, 16'h3000);
        step(); step();
        read_chk("R2", 2, 12054);
        drive_wr(2, 2, 16'h209C);
        step(); step();
        read_chk("R3", 2, 12210);
        drive_wr(3, 1, 8035);
        drive_wr(3, 0, 16'h3000);
        drive_wr(3, 2, 16'h1F64);
        step(); step();
        read_chk("R3", 3, 11898);

        // R4: saturation high
        cur_req = "R4";
        drive_wr(4, 0, 16'h3FFF);
        drive_wr(4, 2, 16'h3FFF);
        step(); step();
        read_chk("R4", 4, 16383);

        // R5: saturation low
        cur_req = "R5";
        drive_wr(5, 0, 100);
        drive_wr(5, 2, 8192 - 200);
        step(); step();
        read_chk("R5", 5, 0);
        drive_wr(5, 0, 0);
        drive_wr(5, 2, 0);
        step(); step();
        read_chk("R5", 5, 0);

        // R9: write lands on the channel being recomputed
        cur_req = "R9";
        rd_ch = 6'd7;
        drive_wr(7, 0, 16'h1000);
        drive_wr(7, 1, 16'h0FFF);
        check("R9", int'(rd_code), 16'h1000, "result with old gain");
        check("R9", int'(busy), 1, "busy kept by colliding write");
        step();
        check("R9", int'(rd_code), 2048, "result with new gain");
        check("R9", int'(busy), 0, "busy after second compute");

        // R10: ignored writes and out-of-range read
        cur_req = "R10";
        drive_wr(6, 3, 0);
        check("R10", int'(busy), 0, "busy after select 3");
        drive_wr(45, 0, 5);
        check("R10", int'(busy), 0, "busy after channel 45");
        read_chk("R10", 45, 0);
        drive_wr(6, 0, 16'h2000);
        step(); step();
        read_chk("R10", 6, 16'h2000);

        // R7, R8: back-to-back writes over many channels, checked every clock
        cur_req = "R7";
        lfsr = 32'h1ACE_B00C;
        for (int k = 0; k < 600; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            rd_ch = CH_W'(lfsr[27:22] % 6'd42);
            if (lfsr[3:0] == 4'd0) step();
            else drive_wr(int'(lfsr[13:8]) % 42, int'(lfsr[5:4]), int'(lfsr[31:18]));
        end
        cur_req = "R8";
        repeat (4) step();
        check("R8", int'(busy), 0, "busy after stream drains");
        for (int ch = 0; ch < NUM_CH; ch++) read_chk("R8", ch, mres[ch]);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule